// File: doc/BRIEF.md
# Doubleword Rotate-and-Clear Execution Unit

This unit executes one 64-bit integer instruction: it rotates a source doubleword left by an immediate amount and then zeroes the bits at both ends that lie outside a window. Its inputs are a 32-bit instruction word and the value already read for its source register. It decodes the opcode and rebuilds the two 6-bit immediates, which are split over non-adjacent instruction bits. It then forms the rotated value, builds the window mask and applies it.

The result, the destination register index and an optional 4-bit condition field are registered and appear one cycle after a valid strobe. A word that does not decode as this instruction produces no write of any kind. The source register index is decoded in the same cycle as the instruction, so the surrounding pipeline can use it to read the register file.

Bits are named here by signal index, where `instr[31]` is the most significant bit. In the result, bit index 63 is the most significant bit.

Top module: `rotclr_unit`

## Requirements
- R1: A word is accepted only when `instr[31:26]` equals 30 and `instr[4:2]` equals 3'b010. Any other word given with `in_valid` leaves `out_valid`, `rd_we` and `cr_we` low in the next cycle.
- R2: For an accepted word, `rd_idx` equals `instr[20:16]`.
- R3: The rotate amount is `{instr[1], instr[15:11]}`, with `instr[1]` as the most significant bit.
- R4: The window start is `{instr[5], instr[10:6]}`, with `instr[5]` as the most significant bit.
- R5: `rd_data` is `src_val` rotated left by the rotate amount and ANDed with a mask. Mask bit i is one exactly when the rotate amount <= i <= 63 minus the window start. This is the same as keeping the most-significant-first positions from the window start through 63 minus the rotate amount.
- R6: When the window start is greater than 63 minus the rotate amount, `rd_data` is zero.
- R7: When the window start is zero, `rd_data` equals `src_val` shifted left logically by the rotate amount.
- R8: When `instr[0]` is set on an accepted word, `cr_we` is high and `cr_field` is {LT, GT, EQ, SO}. LT, GT and EQ give the signed compare of `rd_data` against zero, exactly one of them is set, and SO is a copy of `xer_so`.
- R9: When `instr[0]` is clear, `cr_we` is low and `cr_field` is zero.
- R10: Results appear exactly one clock after the `in_valid` cycle. A cycle without `in_valid` is followed by `out_valid` low.
- R11: While reset is asserted, `out_valid`, `rd_we` and `cr_we` are low in the cycle that follows.
- R12: `src_idx` equals `instr[25:21]` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and source value are present |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Source register value |
| xer_so | input | 1 | Summary-overflow bit to copy into the condition field |
| src_idx | output | 5 | Decoded source register index (combinational) |
| out_valid | output | 1 | Registered result is valid |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Result value |
| cr_we | output | 1 | Condition field write enable |
| cr_field | output | 4 | {LT, GT, EQ, SO} |

## Verification
The result path is driven with rotate amounts and window starts chosen so that each one sets only the high split bit, or only the low five bits. A swapped or misplaced immediate bit then gives a visibly different result. A zero window start is compared against a plain shift, an inverted window checks the empty mask, and a zero amount with a zero start checks that the value passes through unchanged. Negative, positive and zero results, each with both values of the copied summary bit, separate the three compare outcomes. Words with a wrong primary opcode or a wrong extended opcode, and strobes without a valid, show that no write occurs.

// File: rtl/rotclr_pkg.sv
package rotclr_pkg;
    localparam int INSN_W     = 32;
    localparam int REG_IDX_W  = 5;
    localparam int IMM_W      = 6;
    localparam int CRF_W      = 4;
    localparam logic [5:0] OPC_PRIMARY = 6'd30;
    localparam logic [2:0] OPC_EXT     = 3'b010;

    typedef struct packed {
        logic                 hit;
        logic                 rec;
        logic [REG_IDX_W-1:0] rs;
        logic [REG_IDX_W-1:0] ra;
        logic [IMM_W-1:0]     sh;
        logic [IMM_W-1:0]     mb;
    } insn_fields_t;
endpackage

// File: rtl/rotclr_decode.sv
module rotclr_decode
    import rotclr_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output insn_fields_t      fld
);
    always_comb begin
        fld.hit = (insn[31:26] == OPC_PRIMARY) && (insn[4:2] == OPC_EXT);
        fld.rec = insn[0];
        fld.rs  = insn[25:21];
        fld.ra  = insn[20:16];
        // split immediates: the high bit sits apart from the low five
        fld.sh  = {insn[1], insn[15:11]};
        fld.mb  = {insn[5], insn[10:6]};
    end
endmodule

// File: rtl/rotclr_rotator.sv
module rotclr_rotator #(
    parameter int W  = 64,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [0:SW];

    assign stage[0] = din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int D = 2 ** s;
        assign stage[s+1] = amt[s] ? {stage[s][W-1-D:0], stage[s][W-1:W-D]}
                                   : stage[s];
    end

    assign dout = stage[SW];
endmodule

// File: rtl/rotclr_maskgen.sv
module rotclr_maskgen #(
    parameter int W  = 64,
    parameter int SW = $clog2(W)
) (
    input  logic [SW-1:0] start,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  mask
);
    // bit i survives when amt <= i and start <= W-1-i
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [SW:0] LO = (SW+1)'(i);
        localparam logic [SW:0] HI = (SW+1)'(W - 1 - i);
        assign mask[i] = ({1'b0, amt} <= LO) && ({1'b0, start} <= HI);
    end
endmodule

// File: rtl/rotclr_crgen.sv
module rotclr_crgen #(
    parameter int W = 64
) (
    input  logic [W-1:0] res,
    input  logic         so,
    output logic [3:0]   crf
);
    logic neg, zero;

    always_comb begin
        neg  = res[W-1];
        zero = (res == '0);
        crf  = {neg, !neg && !zero, zero, so};
    end
endmodule

// File: rtl/rotclr_unit.sv
module rotclr_unit
    import rotclr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSN_W-1:0]    instr,
    input  logic [DATA_W-1:0]    src_val,
    input  logic                 xer_so,
    output logic [REG_IDX_W-1:0] src_idx,
    output logic                 out_valid,
    output logic                 rd_we,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 cr_we,
    output logic [CRF_W-1:0]     cr_field
);
    localparam int SH_W = $clog2(DATA_W);

    typedef struct packed {
        logic                 valid;
        logic                 we;
        logic [REG_IDX_W-1:0] idx;
        logic [DATA_W-1:0]    data;
        logic                 cr_we;
        logic [CRF_W-1:0]     cr;
    } out_t;

    insn_fields_t       fld;
    logic [DATA_W-1:0]  rot_val;
    logic [DATA_W-1:0]  win_mask;
    logic [DATA_W-1:0]  masked;
    logic [CRF_W-1:0]   cr_calc;
    out_t               out_d, out_q;

    rotclr_decode u_dec (
        .insn (instr),
        .fld  (fld)
    );

    rotclr_rotator #(.W(DATA_W), .SW(SH_W)) u_rot (
        .din  (src_val),
        .amt  (fld.sh[SH_W-1:0]),
        .dout (rot_val)
    );

    rotclr_maskgen #(.W(DATA_W), .SW(SH_W)) u_mask (
        .start (fld.mb[SH_W-1:0]),
        .amt   (fld.sh[SH_W-1:0]),
        .mask  (win_mask)
    );

    assign masked = rot_val & win_mask;

    rotclr_crgen #(.W(DATA_W)) u_cr (
        .res (masked),
        .so  (xer_so),
        .crf (cr_calc)
    );

    always_comb begin
        out_d = '0;
        if (in_valid && fld.hit) begin
            out_d.valid = 1'b1;
            out_d.we    = 1'b1;
            out_d.idx   = fld.ra;
            out_d.data  = masked;
            out_d.cr_we = fld.rec;
            out_d.cr    = fld.rec ? cr_calc : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign src_idx   = fld.rs;
    assign out_valid = out_q.valid;
    assign rd_we     = out_q.we;
    assign rd_idx    = out_q.idx;
    assign rd_data   = out_q.data;
    assign cr_we     = out_q.cr_we;
    assign cr_field  = out_q.cr;
endmodule

// File: rtl/rotclr_unit_chk.sv
module rotclr_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [5:0]        op_hi,
    input logic [4:0]        ra_f,
    input logic [4:0]        sh_lo,
    input logic [4:0]        mb_lo,
    input logic              mb_hi,
    input logic [2:0]        xo_f,
    input logic              sh_hi,
    input logic              rec_f,
    input logic [DATA_W-1:0] src_val,
    input logic              xer_so,
    input logic              out_valid,
    input logic              rd_we,
    input logic [4:0]        rd_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic              cr_we,
    input logic [3:0]        cr_field
);
    logic       hit;
    logic [5:0] shv, mbv;

    assign hit = (op_hi == 6'd30) && (xo_f == 3'b010);
    assign shv = {sh_hi, sh_lo};
    assign mbv = {mb_hi, mb_lo};

    p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !hit) |=> (!out_valid && !rd_we && !cr_we));

    p_dest_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rd_we && rd_idx == $past(ra_f)));

    p_empty_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit && ({1'b0, mbv} + {1'b0, shv} > 7'd63)) |=> (rd_data == '0));

    p_plain_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit && mbv == 6'd0) |=> (rd_data == $past(src_val << shv)));

    p_cr_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit) |=> (cr_we == $past(rec_f)));

    p_cr_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($onehot(cr_field[3:1]) && cr_field[0] == $past(xer_so)));

    p_cr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cr_we |-> (cr_field == 4'd0));

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !rd_we && !cr_we));
endmodule

bind rotclr_unit rotclr_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_hi    (instr[31:26]),
    .ra_f     (instr[20:16]),
    .sh_lo    (instr[15:11]),
    .mb_lo    (instr[10:6]),
    .mb_hi    (instr[5]),
    .xo_f     (instr[4:2]),
    .sh_hi    (instr[1]),
    .rec_f    (instr[0]),
    .src_val  (src_val),
    .xer_so   (xer_so),
    .out_valid(out_valid),
    .rd_we    (rd_we),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .cr_we    (cr_we),
    .cr_field (cr_field)
);

// File: tb/sim_rotclr_unit.sv
`timescale 1ns/1ps
module sim_rotclr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_val = '0;
    logic        xer_so = 1'b0;
    logic [4:0]  src_idx;
    logic        out_valid, rd_we, cr_we;
    logic [4:0]  rd_idx;
    logic [63:0] rd_data;
    logic [3:0]  cr_field;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rotclr_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .xer_so(xer_so), .src_idx(src_idx),
        .out_valid(out_valid), .rd_we(rd_we), .rd_idx(rd_idx),
        .rd_data(rd_data), .cr_we(cr_we), .cr_field(cr_field)
    );

    typedef struct packed {
        logic [63:0] src;
        logic [5:0]  sh;
        logic [5:0]  mb;
        logic        rc;
        logic        so;
        logic [4:0]  ra;
        logic [4:0]  rs;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{64'h0123_4567_89AB_CDEF, 6'd8,  6'd0,  1'b0, 1'b0, 5'd3,  5'd7},
        '{64'h0123_4567_89AB_CDEF, 6'd33, 6'd5,  1'b1, 1'b0, 5'd31, 5'd1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 6'd1,  6'd33, 1'b1, 1'b1, 5'd17, 5'd30},
        '{64'h8000_0000_0000_0001, 6'd63, 6'd0,  1'b1, 1'b0, 5'd0,  5'd16},
        '{64'hDEAD_BEEF_CAFE_F00D, 6'd20, 6'd44, 1'b0, 1'b1, 5'd9,  5'd2},
        '{64'hDEAD_BEEF_CAFE_F00D, 6'd4,  6'd60, 1'b1, 1'b1, 5'd22, 5'd11},
        '{64'h5555_AAAA_3333_CCCC, 6'd16, 6'd16, 1'b1, 1'b0, 5'd12, 5'd25},
        '{64'h7FFF_0000_0000_0000, 6'd0,  6'd1,  1'b1, 1'b0, 5'd5,  5'd5}
    };

    function automatic logic [31:0] mk(input logic [4:0] ra, input logic [4:0] rs,
                                       input logic [5:0] sh, input logic [5:0] mb,
                                       input logic rc);
        return {6'd30, rs, ra, sh[4:0], mb[4:0], mb[5], 3'b010, sh[5], rc};
    endfunction

    // most-significant-first model: position k keeps source position (k+sh) mod 64
    function automatic logic [63:0] model(input logic [63:0] s, input int sh, input int mb);
        logic [63:0] r = '0;
        for (int k = 0; k < 64; k++) begin
            if (k >= mb && k <= 63 - sh)
                r[63 - k] = s[63 - ((k + sh) % 64)];
        end
        return r;
    endfunction

    function automatic logic [3:0] cr_model(input logic [63:0] r, input logic so);
        if ($signed(r) < 0)      return {3'b100, so};
        else if ($signed(r) > 0) return {3'b010, so};
        else                     return {3'b001, so};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [63:0] s, input logic so, input logic v);
        @(negedge clk);
        instr    = w;
        src_val  = s;
        xer_so   = so;
        in_valid = v;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 out_valid in reset", 64'(out_valid), 64'd0);
        chk("R11 rd_we in reset", 64'(rd_we), 64'd0);
        chk("R11 cr_we in reset", 64'(cr_we), 64'd0);
        rst_n = 1'b1;

        // table walk (R2, R5, R8, R9, R12)
        for (int i = 0; i < NV; i++) begin
            logic [63:0] e;
            e = model(VECS[i].src, int'(VECS[i].sh), int'(VECS[i].mb));
            @(negedge clk);
            instr    = mk(VECS[i].ra, VECS[i].rs, VECS[i].sh, VECS[i].mb, VECS[i].rc);
            src_val  = VECS[i].src;
            xer_so   = VECS[i].so;
            in_valid = 1'b1;
            #1 chk("R12 src_idx", 64'(src_idx), 64'(VECS[i].rs));
            @(negedge clk);
            in_valid = 1'b0;
            chk("R1 out_valid on match", 64'(out_valid), 64'd1);
            chk("R2 rd_idx", 64'(rd_idx), 64'(VECS[i].ra));
            chk("R5 rd_data", rd_data, e);
            chk("R8 cr_we", 64'(cr_we), 64'(VECS[i].rc));
            chk("R8 R9 cr_field", 64'(cr_field),
                64'(VECS[i].rc ? cr_model(e, VECS[i].so) : 4'd0));
        end

        // R7 plain shift
        issue(mk(5'd1, 5'd2, 6'd4, 6'd0, 1'b0), 64'h1, 1'b0, 1'b1);
        chk("R7 shift by 4", rd_data, 64'h10);
        // R10 one-cycle latency, no output without in_valid
        @(negedge clk);
        chk("R10 out_valid drops", 64'(out_valid), 64'd0);

        // R6 empty window
        issue(mk(5'd1, 5'd2, 6'd10, 6'd60, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
        chk("R6 empty window data", rd_data, 64'd0);
        chk("R6 zero result EQ", 64'(cr_field), 64'(4'b0010));

        // R3 high shift bit alone
        issue(mk(5'd1, 5'd2, 6'd32, 6'd0, 1'b0), 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1);
        chk("R3 rotate by 32", rd_data, 64'hFFFF_FFFF_0000_0000);
        // R3 low bits alone
        issue(mk(5'd1, 5'd2, 6'd1, 6'd0, 1'b0), 64'h0000_0000_0000_0003, 1'b0, 1'b1);
        chk("R3 rotate by 1", rd_data, 64'h6);

        // R4 high start bit alone
        issue(mk(5'd1, 5'd2, 6'd0, 6'd32, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
        chk("R4 start 32", rd_data, 64'h0000_0000_FFFF_FFFF);
        // R4 low start bits alone
        issue(mk(5'd1, 5'd2, 6'd0, 6'd4, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
        chk("R4 start 4", rd_data, 64'h0FFF_FFFF_FFFF_FFFF);

        // R5 pass-through
        issue(mk(5'd1, 5'd2, 6'd0, 6'd0, 1'b0), 64'hA5A5_0F0F_1234_8765, 1'b0, 1'b1);
        chk("R5 identity", rd_data, 64'hA5A5_0F0F_1234_8765);

        // R8 negative with SO set
        issue(mk(5'd4, 5'd2, 6'd63, 6'd0, 1'b1), 64'h1, 1'b1, 1'b1);
        chk("R8 negative data", rd_data, 64'h8000_0000_0000_0000);
        chk("R8 negative cr", 64'(cr_field), 64'(4'b1001));
        // R8 positive with SO clear
        issue(mk(5'd4, 5'd2, 6'd1, 6'd0, 1'b1), 64'h1, 1'b0, 1'b1);
        chk("R8 positive cr", 64'(cr_field), 64'(4'b0100));
        // R9 record flag clear
        issue(mk(5'd4, 5'd2, 6'd63, 6'd0, 1'b0), 64'h1, 1'b1, 1'b1);
        chk("R9 cr_we low", 64'(cr_we), 64'd0);
        chk("R9 cr_field zero", 64'(cr_field), 64'd0);

        // R1 wrong primary opcode
        issue({6'd31, mk(5'd4, 5'd2, 6'd3, 6'd0, 1'b1)[25:0]}, 64'h1, 1'b0, 1'b1);
        chk("R1 bad opcode out_valid", 64'(out_valid), 64'd0);
        chk("R1 bad opcode rd_we", 64'(rd_we), 64'd0);
        chk("R1 bad opcode cr_we", 64'(cr_we), 64'd0);
        // R1 wrong extended opcode
        issue(mk(5'd4, 5'd2, 6'd3, 6'd0, 1'b1) ^ 32'h0000_000C, 64'h1, 1'b0, 1'b1);
        chk("R1 bad ext out_valid", 64'(out_valid), 64'd0);
        chk("R1 bad ext cr_we", 64'(cr_we), 64'd0);

        // R10 matching word without in_valid
        issue(mk(5'd4, 5'd2, 6'd3, 6'd0, 1'b1), 64'h1, 1'b0, 1'b0);
        chk("R10 no strobe out_valid", 64'(out_valid), 64'd0);
        chk("R10 no strobe rd_we", 64'(rd_we), 64'd0);

        // R11 reset clears a pending result
        @(negedge clk);
        instr = mk(5'd4, 5'd2, 6'd3, 6'd0, 1'b1);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 result before reset", 64'(out_valid), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R11 cr_we after reset", 64'(cr_we), 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule